// File: doc/BRIEF.md
# Interrupt Coalescing Controller

This block sits between a command-completion source and the host interrupt line. Each completion event either raises the interrupt at once or is held back until a programmed number of completions has built up, or until a timer started by the first held completion runs out, whichever comes first. A sticky completion status bit records that an interrupt is due. The interrupt output shows that bit only while a global enable is set. Software clears the bit by writing a one to it.

Software drives the block through a small word-addressed register port with a combinational read path. The port has four words: global control, the count register (threshold and coalescing enable), the timeout register (timer enable and time value), and the status word. Writes take effect on the clock edge that samples them. Reads show the current register and state values.

Top module: `coal_irq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, `irq_o` is low and all four register words read as zero.
- R2: The threshold is the 9-bit field [8:0] of the count register (word 1). Wider values are truncated, so writing 0x200 stores a threshold of zero.
- R3: Bit 16 of the count register is the coalescing enable. Writes to word 1 read back with only bits 16 and [8:0] kept.
- R4: Bit 16 of the timeout register (word 2) is the timer enable and bits [15:0] hold the time value. Both read back as written.
- R5: If coalescing is off (enable bit clear, or threshold zero), every completion sets the status bit on the edge that samples it.
- R6: If coalescing is on, the status bit is set on the edge that samples the threshold-th pending completion.
- R7: If the timer is enabled with a non-zero value V, the status bit is set V cycles after the edge that captured the first pending completion, unless the count condition sets it earlier.
- R8: If the timer is disabled, or its value is zero, pending completions below the threshold never set the status bit.
- R9: Writing 1 to bit 0 of the status word (word 3) clears the status bit, the pending count and the timer. Writing 0 there has no effect. A completion sampled on the same edge as the clear counts as new.
- R10: `irq_o` is high exactly when the status bit and the global enable (bit 0 of word 0) are both set. A write that clears the enable drops the interrupt on that write's edge.
- R11: The status word reads the status bit at bit 0 and the pending count at bits [24:16].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmpl_evt | input | 1 | One completion per cycle when high |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | 2 | Write word address |
| reg_wdata | input | 32 | Write data |
| reg_raddr | input | 2 | Read word address |
| reg_rdata | output | 32 | Read data (combinational) |
| irq_o | output | 1 | Interrupt request |

## Verification
A pending count that is off by one shows as `irq_o` rising one completion early or late, on the edge of that completion. It also shows right away in the pending field of the status word. A timer that starts on the wrong edge, or is not cleared by the W1C write, moves the interrupt rise by whole cycles, and each cycle of the window is compared. A status bit that is not sticky, or a mask that is not applied at once, shows on `irq_o` in the first cycle after the relevant write.

// File: rtl/coal_pkg.sv
// Shared constants for the interrupt coalescing controller.
// Assumes word addressing on a 2-bit register port.
package coal_pkg;
    localparam int CNT_W     = 9;   // threshold / pending count width
    localparam int TMO_W     = 16;  // timer value width
    localparam int EN_BIT    = 16;  // enable bit position in count and timeout words
    localparam int PEND_LSB  = 16;  // pending count position in status word

    localparam logic [1:0] A_CTRL   = 2'd0;
    localparam logic [1:0] A_COUNT  = 2'd1;
    localparam logic [1:0] A_TIMEOUT= 2'd2;
    localparam logic [1:0] A_STATUS = 2'd3;
endpackage

// File: rtl/coal_regs.sv
// Register file for the coalescing controller.
// Holds global enable, count config and timeout config; produces the
// write-one-to-clear pulse and the combinational read mux.
// Assumes one write per cycle and a synchronous active-low reset.
module coal_regs
    import coal_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [1:0]        waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [1:0]        raddr,
    output logic [DATA_W-1:0] rdata,
    input  logic              done,
    input  logic [CNT_W-1:0]  pend,
    output logic              gie,
    output logic              coal_en,
    output logic [CNT_W-1:0]  thresh,
    output logic              tmr_en,
    output logic [TMO_W-1:0]  tmo_val,
    output logic              clr
);
    // Configuration registers updated by software writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gie     <= 1'b0;
            coal_en <= 1'b0;
            thresh  <= '0;
            tmr_en  <= 1'b0;
            tmo_val <= '0;
        end else if (wr) begin
            case (waddr)
                A_CTRL:    gie <= wdata[0];
                A_COUNT: begin
                    coal_en <= wdata[EN_BIT];
                    thresh  <= wdata[CNT_W-1:0];
                end
                A_TIMEOUT: begin
                    tmr_en  <= wdata[EN_BIT];
                    tmo_val <= wdata[TMO_W-1:0];
                end
                default: ;
            endcase
        end
    end

    // Write-one-to-clear pulse for the status bit.
    assign clr = wr && (waddr == A_STATUS) && wdata[0];

    // Combinational read mux.
    always_comb begin
        rdata = '0;
        case (raddr)
            A_CTRL:    rdata[0] = gie;
            A_COUNT: begin
                rdata[EN_BIT]      = coal_en;
                rdata[CNT_W-1:0]   = thresh;
            end
            A_TIMEOUT: begin
                rdata[EN_BIT]      = tmr_en;
                rdata[TMO_W-1:0]   = tmo_val;
            end
            default: begin
                rdata[0]                       = done;
                rdata[PEND_LSB+CNT_W-1:PEND_LSB] = pend;
            end
        endcase
    end

    // R10
    gie_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && waddr == A_CTRL && !wdata[0]) |=> !gie);
endmodule

// File: rtl/coal_engine.sv
// Counting and timing engine. Accumulates completions, runs the timeout
// timer from the first pending completion and sets a sticky status bit.
// Assumes at most one completion per cycle; a clear and a completion on
// the same edge count the completion afresh.
module coal_engine
    import coal_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt,
    input  logic             clr,
    input  logic             coal_en,
    input  logic [CNT_W-1:0] thresh,
    input  logic             tmr_en,
    input  logic [TMO_W-1:0] tmo_val,
    output logic             done,
    output logic [CNT_W-1:0] pend
);
    logic             active, tmr_on;
    logic             done_b, done_n;
    logic [CNT_W-1:0] pend_b, pend_n;
    logic [TMO_W-1:0] tmr, tmr_b, tmr_n;
    logic [TMO_W:0]   tmr_inc;

    assign active  = coal_en && (thresh != '0);
    assign tmr_on  = tmr_en && (tmo_val != '0);

    // Next-state selection: clear first, then count, then timer.
    always_comb begin
        done_b  = clr ? 1'b0 : done;
        pend_b  = clr ? '0   : pend;
        tmr_b   = clr ? '0   : tmr;
        tmr_inc = {1'b0, tmr_b} + 1'b1;
        done_n  = done_b;
        pend_n  = pend_b;
        tmr_n   = tmr_b;
        if (!active) begin
            if (evt) done_n = 1'b1;
            pend_n = '0;
            tmr_n  = '0;
        end else if (!done_b) begin
            if (evt) pend_n = pend_b + 1'b1;
            if (evt && pend_n >= thresh) begin
                done_n = 1'b1;
            end else if (tmr_on && pend_b != '0) begin
                if (tmr_inc >= {1'b0, tmo_val}) done_n = 1'b1;
                else                            tmr_n  = tmr_inc[TMO_W-1:0];
            end
        end
    end

    // State registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0;
            pend <= '0;
            tmr  <= '0;
        end else begin
            done <= done_n;
            pend <= pend_n;
            tmr  <= tmr_n;
        end
    end

    // R9
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !clr) |=> done);
    // R9
    clr_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !evt) |=> (!done && pend == '0));
    // R5
    bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && evt) |=> done);
    // R6
    count_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !done && !clr && evt && ({1'b0, pend} + 1'b1 >= {1'b0, thresh})) |=> done);
endmodule

// File: rtl/coal_irq_ctrl.sv
// Top of the interrupt coalescing controller: register file, engine and
// the global interrupt gate. Synchronous active-low reset.
module coal_irq_ctrl
    import coal_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmpl_evt,
    input  logic              reg_wr,
    input  logic [1:0]        reg_waddr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic [1:0]        reg_raddr,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_o
);
    logic             gie, coal_en, tmr_en, clr, done;
    logic [CNT_W-1:0] thresh, pend;
    logic [TMO_W-1:0] tmo_val;

    coal_regs #(.DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .waddr(reg_waddr),
        .wdata(reg_wdata), .raddr(reg_raddr), .rdata(reg_rdata),
        .done(done), .pend(pend), .gie(gie), .coal_en(coal_en),
        .thresh(thresh), .tmr_en(tmr_en), .tmo_val(tmo_val), .clr(clr)
    );

    coal_engine u_eng (
        .clk(clk), .rst_n(rst_n), .evt(cmpl_evt), .clr(clr),
        .coal_en(coal_en), .thresh(thresh), .tmr_en(tmr_en),
        .tmo_val(tmo_val), .done(done), .pend(pend)
    );

    // Global gate: interrupt only while enabled.
    assign irq_o = done && gie;
endmodule

// File: tb/tb_coal_irq_ctrl.sv
module tb_coal_irq_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmpl_evt = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_waddr = '0;
    logic [31:0] reg_wdata = '0;
    logic [1:0]  reg_raddr = '0;
    logic [31:0] reg_rdata;
    logic        irq_o;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    coal_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .cmpl_evt(cmpl_evt), .reg_wr(reg_wr),
        .reg_waddr(reg_waddr), .reg_wdata(reg_wdata), .reg_raddr(reg_raddr),
        .reg_rdata(reg_rdata), .irq_o(irq_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_waddr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_raddr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic ev();
        @(negedge clk);
        cmpl_evt = 1'b1;
        @(negedge clk);
        cmpl_evt = 1'b0;
    endtask

    task automatic clear();
        wr(2'd3, 32'h1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 irq", {31'b0, irq_o}, 32'h0);
        for (int a = 0; a < 4; a++) begin
            rd(a[1:0], d);
            chk("R1 reg", d, 32'h0);
        end

        // R3 / R4 readback
        wr(2'd1, 32'hFFFF_FE05);
        rd(2'd1, d); chk("R3 count readback", d, 32'h0001_0005);
        wr(2'd2, 32'h0001_ABCD);
        rd(2'd2, d); chk("R4 timeout readback", d, 32'h0001_ABCD);

        // R2 oversize threshold truncates to zero -> immediate (R5)
        wr(2'd0, 32'h1);
        wr(2'd2, 32'h0);
        wr(2'd1, 32'h0001_0200);
        rd(2'd1, d); chk("R2 truncated threshold", d, 32'h0001_0000);
        ev();
        chk("R2 zero threshold immediate", {31'b0, irq_o}, 32'h1);
        clear();

        // R5 coalescing disabled with nonzero threshold; also off pattern
        wr(2'd1, 32'h0000_0004);
        ev();
        chk("R5 disabled immediate", {31'b0, irq_o}, 32'h1);
        clear();
        wr(2'd1, 32'h0); wr(2'd2, 32'h0001_0000);
        ev();
        chk("R5 off pattern immediate", {31'b0, irq_o}, 32'h1);
        clear();

        // R6 threshold sweep with R11 pending readback
        wr(2'd2, 32'h0);
        for (int t = 1; t <= 6; t++) begin
            wr(2'd1, 32'h0001_0000 | t);
            clear();
            for (int n = 1; n <= t; n++) begin
                ev();
                chk("R6 irq vs count", {31'b0, irq_o}, (n >= t) ? 32'h1 : 32'h0);
                rd(2'd3, d);
                chk("R11 status word", d, (n << 16) | ((n >= t) ? 1 : 0));
            end
        end
        clear();

        // R7 timer sweep
        wr(2'd1, 32'h0001_0064);
        for (int v = 1; v <= 8; v++) begin
            wr(2'd2, 32'h0001_0000 | v);
            clear();
            ev();
            chk("R7 after first event", {31'b0, irq_o}, 32'h0);
            for (int k = 1; k <= v + 1; k++) begin
                @(negedge clk);
                chk("R7 timer window", {31'b0, irq_o}, (k >= v) ? 32'h1 : 32'h0);
            end
        end
        clear();

        // R6 count beats a long timer
        wr(2'd1, 32'h0001_0003);
        wr(2'd2, 32'h0001_0014);
        clear();
        ev(); ev();
        chk("R6 before count", {31'b0, irq_o}, 32'h0);
        ev();
        chk("R6 count before timer", {31'b0, irq_o}, 32'h1);
        clear();

        // R8 timer enabled with zero value, and timer disabled
        wr(2'd1, 32'h0001_0005);
        wr(2'd2, 32'h0001_0000);
        clear();
        ev();
        repeat (40) @(negedge clk);
        chk("R8 zero timer value", {31'b0, irq_o}, 32'h0);
        wr(2'd2, 32'h0000_0005);
        clear();
        ev();
        repeat (40) @(negedge clk);
        chk("R8 timer disabled", {31'b0, irq_o}, 32'h0);

        // R9 W1C behaviour
        wr(2'd1, 32'h0);
        ev();
        wr(2'd3, 32'h0);
        chk("R9 write zero no effect", {31'b0, irq_o}, 32'h1);
        clear();
        chk("R9 write one clears", {31'b0, irq_o}, 32'h0);
        // timer restarts after clear
        wr(2'd1, 32'h0001_0064);
        wr(2'd2, 32'h0001_0006);
        clear();
        ev(); ev();
        repeat (2) @(negedge clk);
        clear();
        rd(2'd3, d);
        chk("R9 pending cleared", d, 32'h0);
        repeat (10) @(negedge clk);
        chk("R9 timer cleared", {31'b0, irq_o}, 32'h0);
        ev();
        repeat (5) @(negedge clk);
        chk("R9 timer restart early", {31'b0, irq_o}, 32'h0);
        @(negedge clk);
        chk("R9 timer restart expiry", {31'b0, irq_o}, 32'h1);
        // completion together with clear counts afresh (bypass mode)
        wr(2'd1, 32'h0);
        @(negedge clk);
        reg_wr = 1'b1; reg_waddr = 2'd3; reg_wdata = 32'h1; cmpl_evt = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; cmpl_evt = 1'b0;
        chk("R9 clear with event", {31'b0, irq_o}, 32'h1);

        // R10 global mask
        wr(2'd0, 32'h0);
        chk("R10 masked", {31'b0, irq_o}, 32'h0);
        rd(2'd3, d);
        chk("R10 status kept", d & 32'h1, 32'h1);
        wr(2'd0, 32'h1);
        chk("R10 unmasked", {31'b0, irq_o}, 32'h1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule